// File: doc/BRIEF.md
# Per-Flow Ordering Input Queue

This block is the storage for one virtual channel at a router input, holding single-flit packets. Every flit carries a flow tag and a sequence number within that flow. A new flit is not simply appended. It is sorted into the queue so that the flits of its own flow that are not at the head stay in ascending sequence order. Flits of other flows keep their slots.

Writing uses a valid/ready handshake. An accepted flit waits for one cycle in a staging register. On the next clock edge, one parallel compare-and-shift pass places it in the queue. The head is always visible on a valid/ready read port, and reads carry on while an insertion is in progress. Full and empty flags report the occupancy of the queue itself.

Top module: `ofb_buffer`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1, `full` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: A flit is accepted on a clock edge where `in_valid` and `in_ready` are both 1. In the following cycle `in_ready` is 0. The flit becomes part of the queue on the edge that ends that cycle.
- R3: When the queue holds DEPTH flits, `full` is 1 and `in_ready` is 0. A write offered then is refused and does not appear at the read port.
- R4: A new flit goes to the tail unchanged in either of two cases: only the head is held, or no non-head entry has an equal flow tag (`in_fid`, 4 bits) and a larger sequence number (`in_seq`, 8 bits, compared unsigned).
- R5: Otherwise, every non-head entry of the same flow with a larger sequence number moves at once to the next position held by that flow. The last of them moves to the new tail slot. The new flit takes the first vacated position. Entries of other flows do not move.
- R6: The head entry is never displaced by an insertion, even when it belongs to the same flow and has a larger sequence number.
- R7: `out_valid` is 1 whenever the queue is not empty, and `out_fid`/`out_seq`/`out_pay` show the head. A pop on `out_valid && out_ready` advances every remaining entry by one place.
- R8: A pop and an insertion on the same edge are both carried out. The pop is applied first. The insertion is then sorted against the remaining entries, and the new head is excluded from the sort.
- R9: Reads are not stalled while an insertion is pending. A pop is taken in the cycle after a write was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Write request |
| in_ready | output | 1 | Write can be accepted this cycle |
| in_fid | input | 4 | Flow tag of the incoming flit |
| in_seq | input | 8 | Sequence number of the incoming flit |
| in_pay | input | 16 | Payload of the incoming flit |
| out_valid | output | 1 | Head flit present |
| out_ready | input | 1 | Pop the head |
| out_fid | output | 4 | Flow tag of the head |
| out_seq | output | 8 | Sequence number of the head |
| out_pay | output | 16 | Payload of the head |
| full | output | 1 | Queue holds DEPTH flits |
| empty | output | 1 | Queue holds no flit |

## Verification
The pop from the head and the sorted insertion of a staged flit can complete on the same edge. The bench provokes this by holding `out_ready` high while it writes flits of a few shared flows. The behavioural queue in the bench then pops its front before it sorts the staged flit into the remainder. The two must agree at every clock. When they agree, the bench has shown that the new head is kept out of the sort and that the tail index is taken after the pop.

// File: rtl/ofb_pkg.sv
// Shared widths and the flit record for the per-flow ordering queue.
package ofb_pkg;
    parameter int FID_W = 4;
    parameter int SEQ_W = 8;
    parameter int PAY_W = 16;

    typedef struct packed {
        logic [FID_W-1:0] fid;
        logic [SEQ_W-1:0] seq;
        logic [PAY_W-1:0] pay;
    } flit_t;
endpackage

// File: rtl/ofb_stage.sv
// Staging register: holds an accepted flit for exactly one cycle before
// it is sorted into the queue. Assumes load is only raised when empty.
module ofb_stage
    import ofb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  flit_t din,
    output logic  busy,
    output flit_t dout
);
    // Capture the incoming flit; the slot frees itself one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            dout <= '0;
        end else begin
            busy <= load;
            if (load) dout <= din;
        end
    end
endmodule

// File: rtl/ofb_sort_net.sv
// Parallel insertion network. The post-pop entries (valid bits contiguous
// from slot 0, cnt of them) are compared against the staged flit. Matching
// non-head entries of the same flow with a larger sequence each take the
// value of the previous match (the first takes the new flit), and the last
// displaced value, or the new flit when nothing matches, lands at slot cnt.
// Assumes cnt < DEPTH whenever ins_en is set.
module ofb_sort_net
    import ofb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  flit_t [DEPTH-1:0] slots,
    input  logic  [DEPTH-1:0] vld,
    input  logic  [CNT_W-1:0] cnt,
    input  logic              ins_en,
    input  flit_t             ins,
    output flit_t [DEPTH-1:0] nxt
);
    logic [DEPTH-1:0] hit;

    // Per-slot match: same flow, later sequence, not the head.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit[i] = ins_en && vld[i] && (i != 0) &&
                     (slots[i].fid == ins.fid) && (slots[i].seq > ins.seq);
        end
    end

    // Ripple each displaced value to the next match, then drop the remainder at the tail.
    always_comb begin
        flit_t carry;
        carry = ins;
        for (int i = 0; i < DEPTH; i++) begin
            nxt[i] = slots[i];
            if (hit[i]) begin
                nxt[i] = carry;
                carry  = slots[i];
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (ins_en && (CNT_W'(i) == cnt)) nxt[i] = carry;
        end
    end
endmodule

// File: rtl/ofb_buffer.sv
// Per-flow ordering input queue for one virtual channel. Slot 0 is the head.
// Writes pass through a one-cycle staging register and are sorted in on the
// next edge. A pop on that same edge is applied before the sort. Single-flit
// packets only.
module ofb_buffer
    import ofb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [FID_W-1:0] in_fid,
    input  logic [SEQ_W-1:0] in_seq,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [FID_W-1:0] out_fid,
    output logic [SEQ_W-1:0] out_seq,
    output logic [PAY_W-1:0] out_pay,
    output logic             full,
    output logic             empty
);
    flit_t [DEPTH-1:0] q;
    flit_t [DEPTH-1:0] shifted;
    flit_t [DEPTH-1:0] q_nxt;
    logic  [DEPTH-1:0] vld_s;
    logic  [CNT_W-1:0] count;
    logic  [CNT_W-1:0] cnt_s;
    logic              pop;
    logic              accept;
    logic              pend_v;
    flit_t             pend;
    flit_t             in_flit;

    // Status and handshake decode.
    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign out_valid = !empty;
    assign in_ready  = !pend_v && !full;
    assign accept    = in_valid && in_ready;
    assign pop       = out_valid && out_ready;
    assign in_flit   = '{fid: in_fid, seq: in_seq, pay: in_pay};
    assign out_fid   = q[0].fid;
    assign out_seq   = q[0].seq;
    assign out_pay   = q[0].pay;

    ofb_stage u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .din   (in_flit),
        .busy  (pend_v),
        .dout  (pend)
    );

    // Pop first: every slot takes its successor when the head leaves.
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_pop
            if (g < DEPTH - 1) begin : g_mid
                assign shifted[g] = pop ? q[g+1] : q[g];
            end else begin : g_last
                assign shifted[g] = pop ? '0 : q[g];
            end
            assign vld_s[g] = (CNT_W'(g) < cnt_s);
        end
    endgenerate

    assign cnt_s = count - CNT_W'(pop);

    ofb_sort_net #(.DEPTH(DEPTH)) u_sort (
        .slots  (shifted),
        .vld    (vld_s),
        .cnt    (cnt_s),
        .ins_en (pend_v),
        .ins    (pend),
        .nxt    (q_nxt)
    );

    // Queue storage and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            count <= '0;
        end else begin
            q     <= q_nxt;
            count <= cnt_s + CNT_W'(pend_v);
        end
    end
endmodule

// File: rtl/ofb_chk.sv
// Assertion checker for ofb_buffer, attached by bind. Observes ports only.
module ofb_chk
    import ofb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [FID_W-1:0] out_fid,
    input logic [SEQ_W-1:0] out_seq,
    input logic [PAY_W-1:0] out_pay,
    input logic             full,
    input logic             empty
);
    logic acc_d;

    // Remember that a write was accepted on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_d <= 1'b0;
        else        acc_d <= in_valid && in_ready;
    end

    assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_filled_after_insert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_d |=> !empty);

    assert_no_write_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !in_ready);

    assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_fid) && $stable(out_seq) && $stable(out_pay)));
endmodule

bind ofb_buffer ofb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_fid   (out_fid),
    .out_seq   (out_seq),
    .out_pay   (out_pay),
    .full      (full),
    .empty     (empty)
);

// File: tb/sim_ofb_buffer.sv
module sim_ofb_buffer;
    import ofb_pkg::*;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [FID_W-1:0] in_fid = '0;
    logic [SEQ_W-1:0] in_seq = '0;
    logic [PAY_W-1:0] in_pay = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [FID_W-1:0] out_fid;
    logic [SEQ_W-1:0] out_seq;
    logic [PAY_W-1:0] out_pay;
    logic             full;
    logic             empty;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string req     = "R1";

    // Reference model: a queue of flits plus one staged flit.
    flit_t mq[$];
    bit    pv = 1'b0;
    flit_t pf;
    int    pay_ctr = 1;

    always #4 clk = ~clk;

    ofb_buffer #(.DEPTH(DEPTH)) u0 (.*);

    task automatic chk(bit ok, string r, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic compare();
        bit ev;
        ev = mq.size() > 0;
        chk(out_valid == ev, req, "out_valid", int'(out_valid), int'(ev));
        chk(in_ready == (!pv && mq.size() < DEPTH), req, "in_ready",
            int'(in_ready), int'(!pv && mq.size() < DEPTH));
        chk(full == (mq.size() == DEPTH), "R3", "full", int'(full), int'(mq.size() == DEPTH));
        chk(empty == (mq.size() == 0), req, "empty", int'(empty), int'(mq.size() == 0));
        if (ev) begin
            chk(out_fid == mq[0].fid, req, "head fid", int'(out_fid), int'(mq[0].fid));
            chk(out_seq == mq[0].seq, req, "head seq", int'(out_seq), int'(mq[0].seq));
            chk(out_pay == mq[0].pay, req, "head pay", int'(out_pay), int'(mq[0].pay));
        end
    endtask

    // Behavioural sorted insert: gather later same-flow non-head entries, rotate.
    task automatic model_insert(flit_t f);
        int    idx[$];
        flit_t old[$];
        for (int i = 1; i < mq.size(); i++)
            if (mq[i].fid == f.fid && mq[i].seq > f.seq) idx.push_back(i);
        if (idx.size() == 0) begin
            mq.push_back(f);
        end else begin
            foreach (idx[k]) old.push_back(mq[idx[k]]);
            mq[idx[0]] = f;
            for (int k = 1; k < idx.size(); k++) mq[idx[k]] = old[k-1];
            mq.push_back(old[old.size()-1]);
        end
    endtask

    // One clock: drive at negedge, update model at the edge, compare at next negedge.
    task automatic cyc(bit iv, int fid, int seq, bit ordy);
        bit    acc;
        bit    pp;
        flit_t nf;
        in_valid  = iv;
        in_fid    = FID_W'(fid);
        in_seq    = SEQ_W'(seq);
        in_pay    = PAY_W'(pay_ctr);
        out_ready = ordy;
        nf  = '{fid: FID_W'(fid), seq: SEQ_W'(seq), pay: PAY_W'(pay_ctr)};
        acc = iv && !pv && mq.size() < DEPTH;
        pp  = ordy && mq.size() > 0;
        if (acc) pay_ctr++;
        @(posedge clk);
        if (pp) void'(mq.pop_front());
        if (pv) model_insert(pf);
        pv = acc;
        if (acc) pf = nf;
        @(negedge clk);
        compare();
    endtask

    task automatic wr(int fid, int seq);
        cyc(1, fid, seq, 0);
        cyc(0, 0, 0, 0);
    endtask

    task automatic drain();
        while (mq.size() > 0 || pv) cyc(0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
        chk(full == 1'b0, "R1", "full after reset", int'(full), 0);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        // R2, R4: distinct flows append in arrival order
        req = "R4";
        wr(1, 5); wr(2, 3); wr(3, 1); wr(1, 9);
        req = "R2";
        cyc(1, 4, 4, 0);
        chk(in_ready == 1'b0, "R2", "in_ready low during insert", int'(in_ready), 0);
        cyc(0, 0, 0, 0);
        req = "R7";
        drain();

        // R5: same-flow later entries shift, other flows stay
        req = "R5";
        wr(1, 1); wr(1, 8); wr(2, 7); wr(1, 9); wr(2, 2); wr(1, 4); wr(1, 6);
        drain();

        // R6: head of same flow with larger sequence stays at head
        req = "R6";
        wr(5, 9); wr(5, 2); wr(5, 7); wr(5, 1);
        chk(out_seq == 8'd9, "R6", "head kept", int'(out_seq), 9);
        drain();

        // R3: fill, refuse, drain
        req = "R3";
        for (int i = 0; i < DEPTH; i++) wr(i % 3, DEPTH - i);
        chk(full == 1'b1, "R3", "full at DEPTH", int'(full), 1);
        cyc(1, 7, 7, 0);
        cyc(1, 7, 7, 0);
        drain();

        // R8, R9: insert while popping every cycle
        req = "R8";
        wr(2, 9); wr(2, 8); wr(2, 7);
        for (int i = 0; i < 6; i++) cyc(i % 2 == 0, 2, 6 - i, 1);
        req = "R9";
        cyc(1, 3, 1, 0);
        cyc(0, 0, 0, 1);
        drain();

        // Mixed random traffic over a few flows
        req = "R5";
        for (int i = 0; i < 3000; i++)
            cyc($urandom_range(0, 1) == 1, int'($urandom_range(0, 2)),
                int'($urandom_range(0, 15)), $urandom_range(0, 2) == 0);
        drain();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule